// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a virtual address into a physical address. It walks a multi-level radix page table held in memory. A walk starts at a root table base. At each level one 8-byte entry is read. A pointer entry moves the walk down a level. A leaf entry ends the walk: it is checked against the requested access and the privilege mode. A leaf found above the bottom level maps a large page, and its unused page-number bits are filled from the virtual address. When a leaf's accessed or dirty flag still has to be set, the block either writes the updated entry back to memory or reports a fault, as the update-enable pin selects.

A request is accepted on the cycle that `req_valid` and `req_ready` are both high. `req_ready` is high only while the walker is idle. The request fields are captured at acceptance. The result is presented with `rsp_valid` and is held, unchanged, until the cycle that `rsp_ready` is high. A new request can only be accepted after that.

The memory side has one access in flight at a time. The request is held until `mem_req_ready` is seen high. The response comes back, with no back-pressure, on any later cycle that `mem_rsp_valid` is high. `upd_enable` is a plain level that must stay stable for the whole walk. With the default parameters, the block covers four levels of 9-bit indices, 4 KiB pages and a 56-bit physical address.

Top module: `sv48_walker`

## Requirements
- R1: `req_ready` is high only while idle, and never while `rsp_valid` or `mem_req_valid` is high. After reset the walker is idle. A result stays valid and unchanged until it is taken with `rsp_ready`.
- R2: The walk starts at level LEVELS-1 with the table base set to `req_root`. The entry address at level L is the base plus (VPN field L × 8), where VPN field L is `vaddr[OFS_W+L*IDX_W +: IDX_W]`. A pointer sets the next base to its PPN shifted left by OFS_W.
- R3: A read response with `mem_rsp_err` set ends the walk with status 1 (access fault).
- R4: An entry with V=0, or with W=1 and R=0, ends the walk with status 2 (bad entry). So does a pointer (R=W=X=0) at level 0. Entry bits: V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7, PPN from bit 10 upward.
- R5: `rsp_global` on success is the OR of the G bits of every entry read during the walk.
- R6: A leaf is denied with status 4 when its rights or its privilege do not allow the access.
  - Access codes: 0 is a load, 1 is a store, 2 is a fetch.
  - A load needs R, or X when `req_mxr` is set.
  - A store needs W, and a fetch needs X.
  - A user access (`req_user`=1) needs U.
  - A supervisor access to a U page is allowed only for a load or store with `req_sum` set.
- R7: A leaf at level L>0 whose PPN has any of its low L×IDX_W bits set ends the walk with status 3 (misaligned). This check is made only after the rights check has passed.
- R8: On success (status 0), the result is built as follows:
  - `rsp_paddr` is {leaf PPN OR (VPN AND low-L×IDX_W mask), vaddr page offset}.
  - `rsp_pte` is the final leaf entry and `rsp_pte_addr` is its address.
  - `rsp_level` is L.
- R9: A leaf with A=0, or a store to a leaf with D=0, while `upd_enable` is low, ends the walk with status 5.
- R10: With `upd_enable` high, such a leaf is written back to its own address, with A set (and D set for a store). The written value is returned as `rsp_pte`. A write response with `mem_rsp_err` set gives status 1.
- R11: Exactly one memory read is issued per level visited. The address and write flag of a request stay stable while `mem_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | VA_W | Virtual address |
| req_access | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| req_mxr | input | 1 | Executable pages readable |
| req_sum | input | 1 | Supervisor may touch user data pages |
| req_root | input | PA_W | Root table base address |
| upd_enable | input | 1 | Hardware accessed/dirty update allowed |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | 8-byte aligned entry address |
| mem_req_write | output | 1 | 1 for write-back, 0 for read |
| mem_req_wdata | output | 64 | Entry value to write |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_err | input | 1 | Memory access failed |
| mem_rsp_rdata | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_status | output | 3 | 0 ok, 1 access, 2 bad entry, 3 misaligned, 4 denied, 5 update needed |
| rsp_paddr | output | PA_W | Physical address |
| rsp_pte | output | 64 | Leaf entry (after update) |
| rsp_pte_addr | output | PA_W | Address of leaf entry |
| rsp_level | output | LVL_W | Level of the leaf |
| rsp_global | output | 1 | Global mapping flag |

## Verification
The bench builds the walker with LEVELS=3, IDX_W=2, OFS_W=4 and PA_W=12. This gives a 10-bit virtual space, 8-bit page numbers and a 512-word memory. These values let the bench sweep every virtual address against four pseudo-random table images. Those images mix pointers, leaves at all three levels, aligned and misaligned large pages, read and write error words, and missing A/D bits. Access type, privilege, MXR, SUM, update enable and result back-pressure vary per walk, so every fault kind, the level-0 pointer case and write-back errors are all reached.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int unsigned PTE_W         = 64;
  localparam int unsigned PTE_LOG_BYTES = 3;

  localparam int unsigned PTE_V   = 0;
  localparam int unsigned PTE_R   = 1;
  localparam int unsigned PTE_W_B = 2;
  localparam int unsigned PTE_X   = 3;
  localparam int unsigned PTE_U   = 4;
  localparam int unsigned PTE_G   = 5;
  localparam int unsigned PTE_A   = 6;
  localparam int unsigned PTE_D   = 7;
  localparam int unsigned PPN_LSB = 10;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    ST_OK       = 3'd0,
    ST_BUS_ERR  = 3'd1,
    ST_BAD_PTE  = 3'd2,
    ST_MISALIGN = 3'd3,
    ST_DENIED   = 3'd4,
    ST_NEED_AD  = 3'd5
  } walk_st_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_RD_REQ,
    W_RD_WAIT,
    W_WR_REQ,
    W_WR_WAIT,
    W_DONE
  } walk_state_e;

endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PA_W   = 56,
  localparam int unsigned VPN_W = LEVELS * IDX_W,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PA_W-1:0]  base,
  output logic [PA_W-1:0]  pte_addr
);

  logic [LEVELS-1:0] hit;
  logic [IDX_W-1:0]  sel;

  for (genvar g = 0; g < LEVELS; g++) begin : g_hit
    assign hit[g] = (lvl == LVL_W'(g));
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (hit[i]) sel = vpn[i*IDX_W +: IDX_W];
    end
  end

  assign pte_addr = base + (PA_W'(sel) << ptw_pkg::PTE_LOG_BYTES);

endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
  import ptw_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PPN_W  = 44,
  localparam int unsigned VPN_W = LEVELS * IDX_W,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VPN_W-1:0] vpn,
  input  logic [1:0]       acc,
  input  logic             user,
  input  logic             mxr,
  input  logic             sum,
  output logic             bad,
  output logic             ptr,
  output logic             denied,
  output logic             misalign,
  output logic             need_upd,
  output logic [PPN_W-1:0] ppn_out,
  output logic [PTE_W-1:0] upd_pte
);

  logic r, w, x, u, right_ok, priv_ok, store;
  logic [PPN_W-1:0] ppn, mask;
  logic [PPN_W-1:0] mask_tab [LEVELS];

  assign r     = pte[PTE_R];
  assign w     = pte[PTE_W_B];
  assign x     = pte[PTE_X];
  assign u     = pte[PTE_U];
  assign ppn   = pte[PPN_LSB +: PPN_W];
  assign store = (acc == ACC_STORE);

  // Large-page masks: level g leaves its low g*IDX_W PPN bits to the VPN.
  for (genvar g = 0; g < LEVELS; g++) begin : g_mask
    assign mask_tab[g] = (PPN_W'(1) << (g * IDX_W)) - PPN_W'(1);
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i)) mask = mask_tab[i];
    end
  end

  always_comb begin
    unique case (acc)
      ACC_LOAD:  right_ok = r | (mxr & x);
      ACC_STORE: right_ok = w;
      ACC_FETCH: right_ok = x;
      default:   right_ok = 1'b0;
    endcase
  end

  assign priv_ok  = user ? u : (!u || (sum && acc != ACC_FETCH));
  assign bad      = !pte[PTE_V] || (w && !r);
  assign ptr      = !r && !w && !x;
  assign denied   = !(right_ok && priv_ok);
  assign misalign = |(ppn & mask);
  assign ppn_out  = ppn | (PPN_W'(vpn) & mask);
  assign need_upd = !pte[PTE_A] || (store && !pte[PTE_D]);

  always_comb begin
    upd_pte = pte;
    upd_pte[PTE_A] = 1'b1;
    if (store) upd_pte[PTE_D] = 1'b1;
  end

endmodule

// File: rtl/sv48_walker.sv
module sv48_walker
  import ptw_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned PA_W   = 56,
  localparam int unsigned VPN_W = LEVELS * IDX_W,
  localparam int unsigned VA_W  = VPN_W + OFS_W,
  localparam int unsigned PPN_W = PA_W - OFS_W,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_access,
  input  logic             req_user,
  input  logic             req_mxr,
  input  logic             req_sum,
  input  logic [PA_W-1:0]  req_root,
  input  logic             upd_enable,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic             mem_req_write,
  output logic [63:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [63:0]      mem_rsp_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [2:0]       rsp_status,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [63:0]      rsp_pte,
  output logic [PA_W-1:0]  rsp_pte_addr,
  output logic [LVL_W-1:0] rsp_level,
  output logic             rsp_global
);

  walk_state_e      state;
  walk_st_e         status_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q, mxr_q, sum_q, glob_q;
  logic [PA_W-1:0]  base_q, pte_addr, paddr_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PTE_W-1:0] pte_q, upd_pte;
  logic             bad, ptr, denied, misalign, need_upd;
  logic [PPN_W-1:0] ppn_out;

  ptw_index #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PA_W(PA_W)) u_index (
    .vpn      (va_q[VA_W-1:OFS_W]),
    .lvl      (lvl_q),
    .base     (base_q),
    .pte_addr (pte_addr)
  );

  ptw_leaf #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_leaf (
    .pte      (mem_rsp_rdata),
    .lvl      (lvl_q),
    .vpn      (va_q[VA_W-1:OFS_W]),
    .acc      (acc_q),
    .user     (user_q),
    .mxr      (mxr_q),
    .sum      (sum_q),
    .bad      (bad),
    .ptr      (ptr),
    .denied   (denied),
    .misalign (misalign),
    .need_upd (need_upd),
    .ppn_out  (ppn_out),
    .upd_pte  (upd_pte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= W_IDLE;
      status_q <= ST_OK;
      va_q     <= '0;
      acc_q    <= '0;
      user_q   <= 1'b0;
      mxr_q    <= 1'b0;
      sum_q    <= 1'b0;
      glob_q   <= 1'b0;
      base_q   <= '0;
      lvl_q    <= '0;
      pte_q    <= '0;
      paddr_q  <= '0;
    end else begin
      unique case (state)
        W_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          acc_q  <= req_access;
          user_q <= req_user;
          mxr_q  <= req_mxr;
          sum_q  <= req_sum;
          base_q <= req_root;
          lvl_q  <= LVL_W'(LEVELS - 1);
          glob_q <= 1'b0;
          state  <= W_RD_REQ;
        end
        W_RD_REQ: if (mem_req_ready) state <= W_RD_WAIT;
        W_RD_WAIT: if (mem_rsp_valid) begin
          glob_q <= glob_q | mem_rsp_rdata[PTE_G];
          state  <= W_DONE;
          if (mem_rsp_err) begin
            status_q <= ST_BUS_ERR;
          end else if (bad) begin
            status_q <= ST_BAD_PTE;
          end else if (ptr) begin
            if (lvl_q == '0) begin
              status_q <= ST_BAD_PTE;
            end else begin
              base_q <= {mem_rsp_rdata[PPN_LSB +: PPN_W], {OFS_W{1'b0}}};
              lvl_q  <= lvl_q - LVL_W'(1);
              state  <= W_RD_REQ;
            end
          end else if (denied) begin
            status_q <= ST_DENIED;
          end else if (misalign) begin
            status_q <= ST_MISALIGN;
          end else begin
            paddr_q <= {ppn_out, va_q[OFS_W-1:0]};
            if (!need_upd) begin
              pte_q    <= mem_rsp_rdata;
              status_q <= ST_OK;
            end else if (!upd_enable) begin
              status_q <= ST_NEED_AD;
            end else begin
              pte_q <= upd_pte;
              state <= W_WR_REQ;
            end
          end
        end
        W_WR_REQ: if (mem_req_ready) state <= W_WR_WAIT;
        W_WR_WAIT: if (mem_rsp_valid) begin
          status_q <= mem_rsp_err ? ST_BUS_ERR : ST_OK;
          state    <= W_DONE;
        end
        W_DONE: if (rsp_ready) state <= W_IDLE;
        default: state <= W_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == W_IDLE);
  assign mem_req_valid = (state == W_RD_REQ) || (state == W_WR_REQ);
  assign mem_req_write = (state == W_WR_REQ);
  assign mem_req_addr  = pte_addr;
  assign mem_req_wdata = pte_q;
  assign rsp_valid     = (state == W_DONE);
  assign rsp_status    = status_q;
  assign rsp_paddr     = paddr_q;
  assign rsp_pte       = pte_q;
  assign rsp_pte_addr  = pte_addr;
  assign rsp_level     = lvl_q;
  assign rsp_global    = glob_q;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int unsigned OFS_W = 12,
  parameter int unsigned PA_W  = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFS_W-1:0] req_ofs,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_req_write,
  input logic [63:0]      mem_req_wdata,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [2:0]       rsp_status,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [63:0]      rsp_pte
);

  logic [OFS_W-1:0] ofs_cap;
  logic [PA_W-1:0]  rd_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_cap <= '0;
      rd_cap  <= '0;
    end else begin
      if (req_valid && req_ready) ofs_cap <= req_ofs;
      if (mem_req_valid && mem_req_ready && !mem_req_write) rd_cap <= mem_req_addr;
    end
  end

  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_paddr) && $stable(rsp_pte));

  assert_idle_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid);

  assert_memreq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  assert_wb_abit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[6]);

  assert_wb_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_addr == rd_cap);

  assert_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == 3'd0 |-> rsp_paddr[OFS_W-1:0] == ofs_cap);

  assert_leaf_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == 3'd0 |-> rsp_pte[0] && (rsp_pte[1] || rsp_pte[3]));

endmodule

bind sv48_walker ptw_checker #(.OFS_W(OFS_W), .PA_W(PA_W)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_ofs       (req_vaddr[OFS_W-1:0]),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_write (mem_req_write),
  .mem_req_wdata (mem_req_wdata),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_status    (rsp_status),
  .rsp_paddr     (rsp_paddr),
  .rsp_pte       (rsp_pte)
);

// File: tb/sv48_walker_tb.sv
module sv48_walker_tb;

  localparam int unsigned LEVELS = 3;
  localparam int unsigned IDX_W  = 2;
  localparam int unsigned OFS_W  = 4;
  localparam int unsigned PA_W   = 12;
  localparam int unsigned VA_W   = LEVELS * IDX_W + OFS_W;
  localparam int unsigned WORDS  = 1 << (PA_W - 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic            req_valid = 1'b0, req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0]      req_access = '0;
  logic            req_user = 1'b0, req_mxr = 1'b0, req_sum = 1'b0, upd_enable = 1'b0;
  logic [PA_W-1:0] req_root = '0;
  logic            mem_req_valid, mem_req_write;
  logic            mem_req_ready;
  logic [PA_W-1:0] mem_req_addr;
  logic [63:0]     mem_req_wdata;
  logic            m_rsp_v = 1'b0, m_err = 1'b0;
  logic [63:0]     m_data = '0;
  logic            rsp_valid, rsp_ready = 1'b0, rsp_global;
  logic [2:0]      rsp_status;
  logic [PA_W-1:0] rsp_paddr, rsp_pte_addr;
  logic [63:0]     rsp_pte;
  logic [1:0]      rsp_level;

  sv48_walker #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_access(req_access), .req_user(req_user), .req_mxr(req_mxr), .req_sum(req_sum),
    .req_root(req_root), .upd_enable(upd_enable),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_write(mem_req_write), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(m_rsp_v), .mem_rsp_err(m_err), .mem_rsp_rdata(m_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_paddr(rsp_paddr), .rsp_pte(rsp_pte), .rsp_pte_addr(rsp_pte_addr),
    .rsp_level(rsp_level), .rsp_global(rsp_global)
  );

  // Memory model: one-cycle response, ready stalls on a fixed pattern.
  logic [63:0] mem   [WORDS];
  logic        rerr  [WORDS];
  logic        werr  [WORDS];
  int unsigned cyc = 0, rd_count = 0, wr_count = 0;
  logic [8:0]  m_idx;

  assign mem_req_ready = (cyc % 5) != 3;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    m_rsp_v <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      m_idx = mem_req_addr[PA_W-1:3];
      m_rsp_v <= 1'b1;
      if (mem_req_write) begin
        wr_count <= wr_count + 1;
        m_err    <= werr[m_idx];
        if (!werr[m_idx]) mem[m_idx] <= mem_req_wdata;
      end else begin
        rd_count <= rd_count + 1;
        m_err    <= rerr[m_idx];
        m_data   <= mem[m_idx];
      end
    end
  end

  int unsigned checks = 0, errors = 0;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic fill(input logic [31:0] seed);
    logic [31:0] r;
    logic [63:0] p;
    r = seed;
    for (int i = 0; i < int'(WORDS); i++) begin
      r = nxt(r);
      p = '0;
      p[0] = (r[3:0] != 4'd0);
      p[3:1] = (r[6:4] < 3'd3) ? 3'b000 : r[9:7];
      p[4] = r[10];
      p[5] = r[11] & r[12];
      p[6] = r[13] | r[14];
      p[7] = r[15] | r[16];
      p[17:10] = r[25] ? {r[24:21], 4'b0000} : r[24:17];
      mem[i]  = p;
      rerr[i] = (r[30:26] == 5'd0);
      werr[i] = (r[31:29] == 3'd0);
    end
  endtask

  // Reference walk computed from the requirements.
  task automatic ref_walk(input logic [VA_W-1:0] va, input logic [1:0] acc,
                          input logic usr, input logic mxr, input logic sum, input logic upd,
                          input logic [PA_W-1:0] root,
                          output logic [2:0] st, output logic [PA_W-1:0] pa,
                          output logic [63:0] pte, output logic [PA_W-1:0] pa_pte,
                          output logic [1:0] lvl, output logic g, output logic wr,
                          output int unsigned nrd);
    logic [PA_W-1:0] base, a;
    logic [63:0] p;
    logic [7:0] mask;
    logic ok, pv, need;
    base = root; g = 1'b0; wr = 1'b0; nrd = 0;
    st = 3'd0; pa = '0; pte = '0; pa_pte = '0; lvl = '0;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      a = base + PA_W'({va[OFS_W + l*IDX_W +: IDX_W], 3'b000});
      nrd++;
      if (rerr[a[PA_W-1:3]]) begin st = 3'd1; return; end
      p = mem[a[PA_W-1:3]];
      g = g | p[5];
      if (!p[0] || (p[2] && !p[1])) begin st = 3'd2; return; end
      if (p[3:1] == 3'b000) begin
        if (l == 0) begin st = 3'd2; return; end
        base = {p[17:10], 4'b0000};
        continue;
      end
      case (acc)
        2'd0:    ok = p[1] | (mxr & p[3]);
        2'd1:    ok = p[2];
        default: ok = p[3];
      endcase
      pv = usr ? p[4] : (!p[4] || (sum && acc != 2'd2));
      if (!(ok && pv)) begin st = 3'd4; return; end
      mask = 8'((1 << (2 * l)) - 1);
      if ((p[17:10] & mask) != 8'd0) begin st = 3'd3; return; end
      pa = {p[17:10] | ({2'b00, va[9:4]} & mask), va[3:0]};
      pte = p; pa_pte = a; lvl = 2'(l);
      need = !p[6] || (acc == 2'd1 && !p[7]);
      if (need) begin
        if (!upd) begin st = 3'd5; return; end
        pte = p | 64'h40 | ((acc == 2'd1) ? 64'h80 : 64'h0);
        wr = 1'b1;
        if (werr[a[PA_W-1:3]]) begin st = 3'd1; return; end
      end
      st = 3'd0;
      return;
    end
  endtask

  function automatic string tag_of(input logic [2:0] st, input logic wr);
    case (st)
      3'd0: return "R8";
      3'd1: return wr ? "R10" : "R3";
      3'd2: return "R4";
      3'd3: return "R7";
      3'd4: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic run_walk(input logic [VA_W-1:0] va, input logic [1:0] acc, input logic usr,
                          input logic mxr, input logic sum, input logic upd,
                          input logic [PA_W-1:0] root, input int hold);
    logic [2:0] e_st, got_st;
    logic [PA_W-1:0] e_pa, e_pa_pte;
    logic [63:0] e_pte;
    logic [1:0] e_lvl;
    logic e_g, e_wr;
    int unsigned e_nrd, rd0, wr0;
    int n;
    ref_walk(va, acc, usr, mxr, sum, upd, root, e_st, e_pa, e_pte, e_pa_pte, e_lvl, e_g, e_wr, e_nrd);
    rd0 = rd_count; wr0 = wr_count;
    req_vaddr = va; req_access = acc; req_user = usr; req_mxr = mxr;
    req_sum = sum; upd_enable = upd; req_root = root; req_valid = 1'b1;
    n = 0;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 300) begin @(negedge clk); n++; end
    if (!rsp_valid) begin
      checks++; errors++;
      $display("FAIL R1 no result: actual 0 expected 1");
      return;
    end
    got_st = rsp_status;
    chk(tag_of(e_st, e_wr), "status", 64'(rsp_status), 64'(e_st));
    if (e_st == 3'd0) begin
      chk("R8", "paddr", 64'(rsp_paddr), 64'(e_pa));
      chk("R8", "pte", rsp_pte, e_pte);
      chk("R2", "pte_addr", 64'(rsp_pte_addr), 64'(e_pa_pte));
      chk("R8", "level", 64'(rsp_level), 64'(e_lvl));
      chk("R5", "global", 64'(rsp_global), 64'(e_g));
    end
    chk("R11", "reads", 64'(rd_count - rd0), 64'(e_nrd));
    chk("R10", "writes", 64'(wr_count - wr0), e_wr ? 64'd1 : 64'd0);
    if (e_wr && !werr[e_pa_pte[PA_W-1:3]])
      chk("R10", "written entry", mem[e_pa_pte[PA_W-1:3]], e_pte);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R1", "held valid", 64'(rsp_valid), 64'd1);
      chk("R1", "held status", 64'(rsp_status), 64'(got_st));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R1", "released", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] h;
    logic [PA_W-1:0] root;
    fill(32'h1234_5678);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset req_ready", 64'(req_ready), 64'd1);
    chk("R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    root = '0;
    for (int s = 0; s < 4; s++) begin
      fill(32'h9E37_79B9 * (s + 1) + 32'h55);
      for (int v = 0; v < (1 << VA_W); v++) begin
        h = nxt(32'(v) * 32'h0001_0003 + 32'(s) * 32'h0BAD_F00D + 32'd7);
        if (v % 16 == 0) root = {h[30:23], 4'b0000};
        run_walk(VA_W'(v), 2'(h[3:0] % 3), h[4], h[5], h[6], h[7] | h[8], root, int'(h[10:9]));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule